// File: doc/BRIEF.md
# Ethernet receive address filter

This block sits on the receive path of an Ethernet MAC and gives one keep-or-drop verdict per frame. It watches a byte stream framed by start and end markers. It gathers the six destination octets and folds them into a running CRC-32, and it counts the frame length. When the last byte arrives it checks the destination against two stored unicast addresses and, for group addresses, against a 128-bit hash table. It also checks the length against a programmable minimum so that runt fragments are dropped.

A narrow write port loads the control word, the two unicast addresses and the four hash words into a staging copy. The staging copy becomes active only when a frame starts, so a frame in flight is always judged under one consistent configuration. The verdict appears on a one-cycle strobe in the cycle after the end marker.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_keep` are low until a frame ends.
- R2: A byte is accepted when `in_valid` is high and either `in_sof` is high or a frame is open. When the accepted byte has `in_eof` high, `dec_valid` is high for exactly the following cycle, with the verdict on `dec_keep`.
- R3: With the unicast, multicast and fragment enables all clear, every frame is kept, including a one-byte frame whose start and end markers share a byte.
- R4: A frame is multicast when bit 0 of the first destination octet is set. With the multicast enable set, a multicast frame that is not broadcast is kept only if the hash bit is set. The hash bit is selected by CRC bits 29 down to 23. The CRC starts at all ones, uses polynomial 0x04C11DB7, shifts MSB first with each octet's bits fed LSB first, and has no final inversion.
- R5: Hash words sit at register addresses 4, 5, 6 and 7. They hold indices 0-31, 32-63, 64-95 and 96-127 in that order, and the bit within a word is the index modulo 32.
- R6: With the multicast enable clear, a multicast frame passes the address check.
- R7: The all-ones broadcast address always passes the address check.
- R8: With the unicast enable set, a unicast frame is kept only if all six octets match address A or address B. Register 3 holds octet 1 of A in [31:24], octet 2 of A in [23:16], octet 1 of B in [15:8] and octet 2 of B in [7:0]. Register 1 holds octets 3 to 6 of A, and register 2 holds octets 3 to 6 of B, with octet 3 in [31:24].
- R9: With the unicast enable clear, a unicast frame passes the address check.
- R10: Register 0 holds the unicast enable in bit 0, the multicast enable in bit 1, the fragment enable in bit 2 and the minimum length in [31:16]. The length counts every accepted byte from start marker to end marker. With the fragment enable set, a frame shorter than the minimum is dropped, and a frame of at least the minimum passes the length check.
- R11: With the unicast or the multicast enable set, a frame of fewer than six bytes is dropped.
- R12: A register write is staged. It governs frames that start after the write. A frame already open, or starting in the same cycle as the write, keeps the earlier configuration.
- R13: Bytes offered while no frame is open and without a start marker are ignored and produce no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| dec_valid | output | 1 | Verdict strobe |
| dec_keep | output | 1 | Verdict: 1 keep, 0 drop |

## Verification
Assertions check several rules on every cycle. The verdict strobe must follow an accepted end byte by one cycle. The active configuration may change only at a frame start. A frame judged with every enable clear must be kept, and a short frame under an armed fragment filter must be dropped. Other behaviour depends on particular addresses and lengths, and only the bench scenarios can show it. These cover the CRC-to-hash mapping over all 128 indices, the placement of unicast octets across the three registers, the exact minimum-length boundary and the staging of writes made during a frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int LEN_W      = 16;
  localparam int DA_BYTES   = 6;
  localparam int HASH_WORDS = 4;
  localparam int HASH_BITS  = HASH_WORDS * 32;
  localparam int IDX_W      = $clog2(HASH_BITS);
  localparam int IDX_LO     = 23;
  localparam int IDX_HI     = IDX_LO + IDX_W - 1;
  localparam int RA_W       = 3;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  localparam logic [RA_W-1:0] RA_CTRL  = 3'd0;
  localparam logic [RA_W-1:0] RA_A_LO  = 3'd1;
  localparam logic [RA_W-1:0] RA_B_LO  = 3'd2;
  localparam logic [RA_W-1:0] RA_AB_HI = 3'd3;

  typedef struct packed {
    logic [HASH_WORDS-1:0][31:0] hash;
    logic [31:0]      ab_hi;
    logic [31:0]      b_lo;
    logic [31:0]      a_lo;
    logic [LEN_W-1:0] min_len;
    logic             frag_en;
    logic             mc_en;
    logic             uni_en;
  } cfg_t;

  // One octet of the running CRC: MSB-first register, octet bits LSB first.
  function automatic logic [31:0] crc_octet(input logic [31:0] c_in,
                                            input logic [7:0]  oct);
    logic [31:0] c;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      if (c[31] ^ oct[b]) c = {c[30:0], 1'b0} ^ CRC_POLY;
      else                c = {c[30:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/rxf_cfg.sv
module rxf_cfg
  import rxf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RA_W-1:0] wr_addr,
  input  logic [31:0]     wr_data,
  input  logic            frame_start,
  output cfg_t            cfg_now
);
  cfg_t stage_q, stage_d;
  cfg_t act_q, act_d;

  always_comb begin
    stage_d = stage_q;
    if (wr_en) begin
      case (wr_addr)
        RA_CTRL: begin
          stage_d.uni_en  = wr_data[0];
          stage_d.mc_en   = wr_data[1];
          stage_d.frag_en = wr_data[2];
          stage_d.min_len = wr_data[31:16];
        end
        RA_A_LO:  stage_d.a_lo  = wr_data;
        RA_B_LO:  stage_d.b_lo  = wr_data;
        RA_AB_HI: stage_d.ab_hi = wr_data;
        default:  stage_d.hash[wr_addr[1:0]] = wr_data;
      endcase
    end
  end

  always_comb begin
    act_d = act_q;
    if (frame_start) act_d = stage_q;
  end

  assign cfg_now = act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      if (wr_en)       stage_q <= stage_d;
      if (frame_start) act_q   <= act_d;
    end
  end

  // R12: the judged configuration only moves at a frame start
  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> $stable(act_q));
endmodule

// File: rtl/rxf_hash.sv
module rxf_hash
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_en,
  input  logic             first,
  input  logic             take,
  input  logic [7:0]       data,
  output logic [IDX_W-1:0] idx
);
  logic [31:0] crc_q, crc_d, crc_base, crc_upd;

  always_comb begin
    crc_base = first ? 32'hFFFF_FFFF : crc_q;
    crc_upd  = crc_octet(crc_base, data);
    crc_d    = (byte_en && take) ? crc_upd : crc_q;
  end

  assign idx = crc_d[IDX_HI:IDX_LO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= '0;
    else if (byte_en) crc_q <= crc_d;
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_sof,
  input  logic            in_eof,
  input  logic [7:0]      in_data,
  input  logic            wr_en,
  input  logic [RA_W-1:0] wr_addr,
  input  logic [31:0]     wr_data,
  output logic            dec_valid,
  output logic            dec_keep
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic                          open_q, open_d;
  logic [LEN_W-1:0]              cnt_q, cnt_d, pos, len_now;
  logic [DA_BYTES-1:0][7:0]      da_q, da_now;
  logic                          byte_en, first, take, da_full;
  logic [IDX_W-1:0]              idx;
  cfg_t                          cfg_now;
  logic [8*DA_BYTES-1:0]         da_vec, a_vec, b_vec;
  logic [HASH_BITS-1:0]          hash_flat;
  logic                          is_mc, is_bc, hit_a, hit_b, hash_hit;
  logic                          addr_ok, len_ok, keep_now;
  logic                          dv_d, dk_d;

  assign byte_en = in_valid && (in_sof || open_q);
  assign first   = in_valid && in_sof;
  assign pos     = in_sof ? '0 : cnt_q;
  assign len_now = (pos == LEN_MAX) ? pos : pos + 1'b1;
  assign take    = pos < LEN_W'(DA_BYTES);
  assign da_full = len_now >= LEN_W'(DA_BYTES);

  for (genvar i = 0; i < DA_BYTES; i++) begin : g_da
    assign da_now[i] = (take && pos == LEN_W'(i)) ? in_data : da_q[i];
    assign da_vec[8*(DA_BYTES-i)-1 -: 8] = da_now[i];
  end

  rxf_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_start(first), .cfg_now(cfg_now)
  );

  rxf_hash u_hash (
    .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .first(first),
    .take(take), .data(in_data), .idx(idx)
  );

  always_comb begin
    a_vec     = {cfg_now.ab_hi[31:16], cfg_now.a_lo};
    b_vec     = {cfg_now.ab_hi[15:0],  cfg_now.b_lo};
    hash_flat = cfg_now.hash;
    is_mc     = da_now[0][0];
    is_bc     = &da_vec;
    hit_a     = da_vec == a_vec;
    hit_b     = da_vec == b_vec;
    hash_hit  = hash_flat[idx];
    if (is_bc)      addr_ok = 1'b1;
    else if (is_mc) addr_ok = !cfg_now.mc_en || hash_hit;
    else            addr_ok = !cfg_now.uni_en || hit_a || hit_b;
    if ((cfg_now.uni_en || cfg_now.mc_en) && !da_full) addr_ok = 1'b0;
    len_ok   = !cfg_now.frag_en || (len_now >= cfg_now.min_len);
    keep_now = addr_ok && len_ok;
  end

  always_comb begin
    open_d = open_q;
    cnt_d  = cnt_q;
    if (byte_en) begin
      open_d = !in_eof;
      cnt_d  = len_now;
    end
    dv_d = byte_en && in_eof;
    dk_d = dv_d && keep_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      cnt_q     <= '0;
      da_q      <= '0;
      dec_valid <= 1'b0;
      dec_keep  <= 1'b0;
    end else begin
      if (byte_en) begin
        open_q <= open_d;
        cnt_q  <= cnt_d;
        da_q   <= da_now;
      end
      dec_valid <= dv_d;
      dec_keep  <= dk_d;
    end
  end

  // R2: a verdict strobe only follows an accepted end byte
  assert_dec_after_eof_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid && in_eof && (in_sof || open_q)));

  // R3: with every filter disabled the frame is kept
  assert_open_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(!cfg_now.uni_en && !cfg_now.mc_en && !cfg_now.frag_en))
      |-> dec_keep);

  // R10: a runt under an armed fragment filter is dropped
  assert_runt_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(cfg_now.frag_en && (len_now < cfg_now.min_len)))
      |-> !dec_keep);
endmodule

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sof, in_eof;
  logic [7:0] in_data;
  logic wr_en;
  logic [2:0] wr_addr;
  logic [31:0] wr_data;
  logic dec_valid, dec_keep;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  rx_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dec_valid(dec_valid), .dec_keep(dec_keep)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Hash index from the requirement's CRC definition; octet 1 at [47:40].
  function automatic logic [6:0] hidx(input logic [47:0] da);
    logic [31:0] c;
    logic [7:0]  o;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int j = 0; j < 6; j++) begin
      o = da[47-8*j -: 8];
      for (int i = 0; i < 8; i++) begin
        fb = c[31] ^ o[i];
        c  = c << 1;
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    end
    return c[29:23];
  endfunction

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Sends one frame starting at the next falling edge; returns the verdict.
  task automatic frame(input logic [47:0] da, input int len, output logic v, output logic k);
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (b == 0);
      in_eof   = (b == len - 1);
      in_data  = (b < 6) ? da[47-8*b -: 8] : 8'(b * 7 + 3);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    #0.5;
    v = dec_valid;
    k = dec_keep;
  endtask

  task automatic judge(input string req, input logic [47:0] da, input int len, input logic exp);
    logic v, k;
    frame(da, len, v, k);
    check(req, {31'd0, v}, 32'd1);
    check(req, {31'd0, k}, {31'd0, exp});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [47:0] mtab [128];
    bit          got  [128];
    int          found;
    logic [31:0] pat [4];
    logic [47:0] bcast, ua, ub;
    logic v, k;

    rst_n = 1'b0; in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0;
    bcast = 48'hFFFF_FFFF_FFFF;
    ua = 48'h0211_2233_4455;
    ub = 48'h0677_AABB_CCDD;

    // find one multicast address per hash index
    found = 0;
    for (int i = 0; i < 128; i++) got[i] = 0;
    for (int n = 0; n < 65536 && found < 128; n++) begin
      logic [47:0] a;
      logic [6:0]  h;
      a = {32'h0100_5E00, 16'(n)};
      h = hidx(a);
      if (!got[h]) begin got[h] = 1; mtab[h] = a; found++; end
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    check("R1 valid", {31'd0, dec_valid}, 32'd0);
    check("R1 keep",  {31'd0, dec_keep},  32'd0);

    // R3: everything open, one-byte and unicast frames kept
    judge("R3 single byte", 48'h1200_0000_0000, 1, 1'b1);
    judge("R3 unicast", 48'h0A0B_0C0D_0E0F, 20, 1'b1);

    // R2: strobe lasts exactly one cycle
    @(negedge clk); #0.5;
    check("R2 pulse ends", {31'd0, dec_valid}, 32'd0);

    // R13: stray byte outside a frame
    @(negedge clk);
    in_valid = 1; in_sof = 0; in_eof = 1; in_data = 8'h55;
    @(negedge clk);
    in_valid = 0; in_eof = 0; #0.5;
    check("R13 stray byte", {31'd0, dec_valid}, 32'd0);

    // R4/R5: hash sweep over all 128 indices with two patterns
    check("R4 all indices found", found, 128);
    wreg(3'd0, 32'h0000_0002);
    pat[0] = 32'hA5C3_0F96; pat[1] = 32'h1234_8001;
    pat[2] = 32'hF00D_C3A5; pat[3] = 32'h8000_7FFE;
    for (int p = 0; p < 2; p++) begin
      for (int w = 0; w < 4; w++) wreg(3'(4 + w), p == 0 ? pat[w] : ~pat[w]);
      for (int i = 0; i < 128; i++) begin
        logic e;
        e = (p == 0) ? pat[i / 32][i % 32] : ~pat[i / 32][i % 32];
        judge("R4 R5 hash", mtab[i], 8, e);
      end
    end

    // R7: broadcast with empty hash and both address filters on
    for (int w = 0; w < 4; w++) wreg(3'(4 + w), 32'd0);
    wreg(3'd0, 32'h0000_0003);
    judge("R7 broadcast", bcast, 10, 1'b1);
    judge("R4 empty hash drops", mtab[5], 10, 1'b0);

    // R8: unicast matching and register layout
    wreg(3'd1, 32'h2233_4455);
    wreg(3'd2, 32'hAABB_CCDD);
    wreg(3'd3, 32'h0211_0677);
    judge("R8 address A", ua, 12, 1'b1);
    judge("R8 address B", ub, 12, 1'b1);
    judge("R8 B high A low", 48'h0677_2233_4455, 12, 1'b0);
    judge("R8 A high B low", 48'h0211_AABB_CCDD, 12, 1'b0);
    judge("R8 last octet", 48'h0211_2233_4456, 12, 1'b0);
    // R11: short frame with matching prefix
    judge("R11 short frame", ua, 5, 1'b0);

    // R6: multicast enable clear, unicast on
    wreg(3'd0, 32'h0000_0001);
    for (int i = 0; i < 128; i += 37) judge("R6 mc pass", mtab[i], 8, 1'b1);
    judge("R8 mismatch drops", 48'h0211_2233_0000, 8, 1'b0);

    // R9: unicast enable clear, multicast on
    wreg(3'd0, 32'h0000_0002);
    judge("R9 unicast pass", 48'h0A0B_0C0D_0E0F, 8, 1'b1);
    judge("R11 short mc-on", bcast, 4, 1'b0);

    // R10: length sweep around a 64-byte minimum
    wreg(3'd0, {16'd64, 16'h0004});
    for (int n = 1; n <= 80; n++) judge("R10 length", bcast, n, n >= 64);

    // R12: write during an open frame applies to the next frame
    wreg(3'd0, 32'h0000_0000);
    for (int b = 0; b < 10; b++) begin
      @(negedge clk);
      in_valid = 1; in_sof = (b == 0); in_eof = (b == 9); in_data = 8'hFF;
      wr_en = (b == 3); wr_addr = 3'd0; wr_data = {16'd40, 16'h0004};
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; wr_en = 0; #0.5;
    check("R12 old config valid", {31'd0, dec_valid}, 32'd1);
    check("R12 old config keep",  {31'd0, dec_keep},  32'd1);
    judge("R12 new config", bcast, 10, 1'b0);
    frame(bcast, 40, v, k);
    check("R12 at minimum", {30'd0, v, k}, 32'd3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule